// File: doc/BRIEF.md
# Shadow-Buffered Single-Channel PWM Generator

This block produces one pulse-width-modulated output from an up-counting timebase. Software sets a period and a compare value over a simple register bus. The counter runs from zero up to the period value and then returns to zero, so one waveform cycle lasts period+1 clocks. With normal polarity, the output is high while the count is below the compare value. With inverted polarity, the compare value sets the low time instead.

Each of the two timing values has two registers. The active register is used by the compare logic and can be written at any time. The staged copy is held until the next rollover and is then moved into the active register. This lets a running waveform be retimed without cutting a cycle short. A 16-bit control word turns the output on, selects the polarity, starts or stops the counter, and chooses whether a sync pulse may clear the count.

Top module: `aux_pwm`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped and `pwm_out` is low.
- R2: A read returns the last value written. Period (byte offset 0x08), compare (0x0C), staged period (0x10) and staged compare (0x14) are 32 bits wide. The control word (0x2A) keeps `bus_wdata[15:0]` and reads back zero-extended.
- R3: Control bit 4 set makes the counter count up by one per clock and return to 0 on the clock after it reaches the active period, giving period+1 clocks per cycle. With bit 4 clear, the count holds.
- R4: With control bit 9 set and bit 10 clear, `pwm_out` is high for exactly `compare` clocks of each cycle. Compare 0 gives a constant low. A compare value above the period gives a constant high.
- R5: With control bits 9 and 10 both set, the output is inverted and is low for exactly `compare` clocks of each cycle.
- R6: With control bit 9 clear, `pwm_out` stays low whatever bit 10 holds.
- R7: A write to the active period or compare register takes effect on the next clock, even while the counter runs.
- R8: A write to a staged register marks it pending and leaves the active value alone. At the next rollover the pending value moves into the active register and the mark clears.
- R9: If a staged write lands on the same clock as a rollover, the older pending value (if any) moves to the active register. The new value stays pending until the following rollover.
- R10: When control bits 7:6 are not both set, a high `sync_in` clears a running count to 0. When bits 7:6 are both 1, `sync_in` is ignored.
- R11: A period of 1 with compare 1 gives a valid waveform that alternates high and low on every clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_addr | input | AW (8) | Byte address of the register |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data for `bus_addr`, combinational |
| sync_in | input | 1 | Counter clear request, honoured only when sync is selected |
| pwm_out | output | 1 | Registered PWM output |

## Verification
Two events can fall on the same clock: a write to a staged register and a period rollover that moves the pending contents into the active registers. The bench creates this overlap on purpose. It starts the counter from a known stopped state with a short period, so it knows the exact clock of the first rollover. It then times a staged write to arrive on that clock. The result is judged in two ways. Readback must show that the older staged value became active while the new one is still held. A reference model, fed through the scoreboard queue, must then match the waveform clock by clock across both of the following rollovers.

// File: rtl/aux_pwm_pkg.sv
// Package: shared register offsets, control-bit positions and decode helper
// for the shadow-buffered PWM. Assumes byte addressing on an 8-bit map.
package aux_pwm_pkg;

    localparam logic [7:0] OFS_PER    = 8'h08;
    localparam logic [7:0] OFS_CMP    = 8'h0C;
    localparam logic [7:0] OFS_PER_SH = 8'h10;
    localparam logic [7:0] OFS_CMP_SH = 8'h14;
    localparam logic [7:0] OFS_CTL    = 8'h2A;

    localparam int CTL_W    = 16;
    localparam int BIT_RUN  = 4;
    localparam int BIT_SYN0 = 6;
    localparam int BIT_SYN1 = 7;
    localparam int BIT_MODE = 9;
    localparam int BIT_POL  = 10;

    typedef struct packed {
        logic run;
        logic mode;
        logic pol;
        logic sync_en;
    } ctl_view_t;

    // Turn the raw control word into the handful of fields the datapath uses.
    function automatic ctl_view_t decode_ctl(input logic [CTL_W-1:0] c);
        ctl_view_t v;
        v.run     = c[BIT_RUN];
        v.mode    = c[BIT_MODE];
        v.pol     = c[BIT_POL];
        v.sync_en = ~(c[BIT_SYN1] & c[BIT_SYN0]);
        return v;
    endfunction

endpackage

// File: rtl/aux_pwm_dbuf.sv
// Module: one double-buffered timing value (active + staged + pending flag).
// Assumes wr_act and wr_sh are never both high (distinct addresses) and that
// xfer pulses for exactly one clock per rollover.
module aux_pwm_dbuf #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_act,
    input  logic          wr_sh,
    input  logic [DW-1:0] wdata,
    input  logic          xfer,
    output logic [DW-1:0] act,
    output logic [DW-1:0] sh
);

    logic pend;

    // Update the staged copy, the active copy and the pending mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act  <= '0;
            sh   <= '0;
            pend <= 1'b0;
        end else begin
            if (wr_sh)
                sh <= wdata;
            if (wr_act)
                act <= wdata;
            else if (xfer && pend)
                act <= sh;
            if (wr_sh)
                pend <= 1'b1;
            else if (xfer)
                pend <= 1'b0;
        end
    end

    // R8: a pending value moves to the active register at rollover
    a_r8_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && pend && !wr_act |=> act == $past(sh));
    // R8: without rollover or direct write the active value holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer && !wr_act |=> $stable(act));
    // R9: a staged write always leaves a pending value behind
    a_r9_repend: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sh |=> pend);
    // R8: rollover without a new write clears the pending mark
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        xfer && !wr_sh |=> !pend);

endmodule

// File: rtl/aux_pwm_regs.sv
// Module: register file. Holds the control word and the two double-buffered
// timing values and provides combinational readback. Assumes one bus write per clock.
module aux_pwm_regs
    import aux_pwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata,
    input  logic             wrap,
    output logic [DW-1:0]    per_act,
    output logic [DW-1:0]    cmp_act,
    output logic [CTL_W-1:0] ctl
);

    localparam int NSLOT = 2;

    logic [DW-1:0] act_q [NSLOT];
    logic [DW-1:0] sh_q  [NSLOT];

    // Slot 0 carries the period and slot 1 the compare value.
    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        localparam logic [7:0] A_OFS = (g == 0) ? OFS_PER    : OFS_CMP;
        localparam logic [7:0] S_OFS = (g == 0) ? OFS_PER_SH : OFS_CMP_SH;
        aux_pwm_dbuf #(.DW(DW)) u_dbuf (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_act (wr && (addr == AW'(A_OFS))),
            .wr_sh  (wr && (addr == AW'(S_OFS))),
            .wdata  (wdata),
            .xfer   (wrap),
            .act    (act_q[g]),
            .sh     (sh_q[g])
        );
    end

    assign per_act = act_q[0];
    assign cmp_act = act_q[1];

    // Store the lower half of a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl <= '0;
        else if (wr && (addr == AW'(OFS_CTL)))
            ctl <= wdata[CTL_W-1:0];
    end

    // Select the register addressed for readback.
    always_comb begin
        rdata = '0;
        if (addr == AW'(OFS_PER))         rdata = act_q[0];
        else if (addr == AW'(OFS_CMP))    rdata = act_q[1];
        else if (addr == AW'(OFS_PER_SH)) rdata = sh_q[0];
        else if (addr == AW'(OFS_CMP_SH)) rdata = sh_q[1];
        else if (addr == AW'(OFS_CTL))    rdata = DW'(ctl);
    end

    // R2: the control word takes the low half of a write to its offset
    a_r2_ctl_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr && (addr == AW'(OFS_CTL)) |=> ctl == $past(wdata[CTL_W-1:0]));

endmodule

// File: rtl/aux_pwm_timebase.sv
// Module: up-counter with period rollover and optional sync clear.
// Assumes per is stable except at bus writes and rollovers. The >= compare
// recovers cleanly when the period is lowered below the running count.
module aux_pwm_timebase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          sync_en,
    input  logic          sync_in,
    input  logic [DW-1:0] per,
    output logic [DW-1:0] cnt,
    output logic          wrap
);

    logic sync_hit;

    // Flag the last clock of a waveform cycle and a usable sync request.
    always_comb begin
        wrap     = run && (cnt >= per);
        sync_hit = run && sync_en && sync_in;
    end

    // Advance, clear or hold the count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (run) begin
            if (sync_hit || wrap)
                cnt <= '0;
            else
                cnt <= cnt + DW'(1);
        end
    end

    // R3: a stopped counter holds its value
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt));
    // R3: reaching the period returns the count to zero
    a_r3_rollover: assert property (@(posedge clk) disable iff (!rst_n)
        run && (cnt >= per) |=> cnt == '0);
    // R3: below the period, with no sync, the count steps by one
    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        run && (cnt < per) && !(sync_en && sync_in) |=> cnt == $past(cnt) + DW'(1));
    // R10: with sync selected, a sync request clears the count
    a_r10_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
        run && sync_en && sync_in |=> cnt == '0);
    // R10: with sync deselected, sync_in has no effect on counting
    a_r10_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
        run && !sync_en && (cnt < per) |=> cnt == $past(cnt) + DW'(1));

endmodule

// File: rtl/aux_pwm_outdrv.sv
// Module: compare and polarity stage with a registered, glitch-free output.
// Assumes cnt and cmp come from registers in the same clock domain.
module aux_pwm_outdrv #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-1:0] cnt,
    input  logic [DW-1:0] cmp,
    input  logic          mode,
    input  logic          pol,
    output logic          pwm_out
);

    logic below;

    // Compare result: true while the count has not reached the compare value.
    always_comb below = (cnt < cmp);

    // Register the output level, forced low while the mode bit is clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwm_out <= 1'b0;
        else
            pwm_out <= mode & (below ^ pol);
    end

    // R6: with the mode bit clear the output is low on the next clock
    a_r6_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> !pwm_out);
    // R4: normal polarity, count below compare, drives high
    a_r4_high_time: assert property (@(posedge clk) disable iff (!rst_n)
        mode && !pol && (cmp > cnt) |=> pwm_out);
    // R5: inverted polarity, count below compare, drives low
    a_r5_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        mode && pol && (cmp > cnt) |=> !pwm_out);
    // R4: compare of zero never produces a high level in normal polarity
    a_r4_zero_cmp: assert property (@(posedge clk) disable iff (!rst_n)
        mode && !pol && (cmp == '0) |=> !pwm_out);

endmodule

// File: rtl/aux_pwm.sv
// Module: top of the shadow-buffered PWM. Wires the register file, timebase
// and output stage together. Assumes a single clock and synchronous reset.
module aux_pwm
    import aux_pwm_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          sync_in,
    output logic          pwm_out
);

    logic [DW-1:0]    per_act;
    logic [DW-1:0]    cmp_act;
    logic [DW-1:0]    cnt;
    logic [CTL_W-1:0] ctl;
    logic             wrap;
    ctl_view_t        cv;

    // Pull the live control fields out of the raw word.
    always_comb cv = decode_ctl(ctl);

    aux_pwm_regs #(.DW(DW), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (bus_wr),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .wrap    (wrap),
        .per_act (per_act),
        .cmp_act (cmp_act),
        .ctl     (ctl)
    );

    aux_pwm_timebase #(.DW(DW)) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (cv.run),
        .sync_en (cv.sync_en),
        .sync_in (sync_in),
        .per     (per_act),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    aux_pwm_outdrv #(.DW(DW)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt     (cnt),
        .cmp     (cmp_act),
        .mode    (cv.mode),
        .pol     (cv.pol),
        .pwm_out (pwm_out)
    );

    // R1: the cycle after reset shows a low output
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> !pwm_out);

endmodule

// File: tb/tb_aux_pwm.sv
module tb_aux_pwm;

    localparam int DW = 32;
    localparam int AW = 8;
    localparam logic [7:0] A_PER = 8'h08, A_CMP = 8'h0C, A_PSH = 8'h10,
                           A_CSH = 8'h14, A_CTL = 8'h2A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_wdata = '0;
    logic [DW-1:0] bus_rdata;
    logic          sync_in = 1'b0;
    logic          pwm_out;

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string cur_req = "R1";
    bit    exp_q[$];

    aux_pwm #(.DW(DW), .AW(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sync_in(sync_in),
        .pwm_out(pwm_out)
    );

    always #2 clk = ~clk;

    // Reference model state, built from the requirements.
    logic [DW-1:0] m_cnt, m_per, m_cmp, m_psh, m_csh;
    logic [15:0]   m_ctl;
    bit            m_pp, m_cp;

    // Model step per clock: push the expected next output, then update the state.
    always @(posedge clk) begin
        bit run, wrap, snc, nout;
        if (!rst_n) begin
            m_cnt = '0; m_per = '0; m_cmp = '0; m_psh = '0; m_csh = '0;
            m_ctl = '0; m_pp = 0; m_cp = 0;
            exp_q.push_back(1'b0);
        end else begin
            run  = m_ctl[4];
            wrap = run && (m_cnt >= m_per);
            snc  = run && !(m_ctl[7] && m_ctl[6]) && sync_in;
            nout = m_ctl[9] ? ((m_cnt < m_cmp) ^ m_ctl[10]) : 1'b0;
            exp_q.push_back(nout);
            if (run) m_cnt = (snc || wrap) ? '0 : m_cnt + 1;
            if (bus_wr && bus_addr == A_PER) m_per = bus_wdata;
            else if (wrap && m_pp) m_per = m_psh;
            if (bus_wr && bus_addr == A_CMP) m_cmp = bus_wdata;
            else if (wrap && m_cp) m_cmp = m_csh;
            if (bus_wr && bus_addr == A_PSH) begin m_psh = bus_wdata; m_pp = 1; end
            else if (wrap) m_pp = 0;
            if (bus_wr && bus_addr == A_CSH) begin m_csh = bus_wdata; m_cp = 1; end
            else if (wrap) m_cp = 0;
            if (bus_wr && bus_addr == A_CTL) m_ctl = bus_wdata[15:0];
        end
    end

    // Scoreboard monitor: compare each produced output with the queued expectation.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            bit e;
            e = exp_q.pop_front();
            checks++;
            if (pwm_out !== e) begin
                fails++;
                $display("FAIL %s waveform: pwm_out=%0b expected=%0b at %0t", cur_req, pwm_out, e, $time);
            end
        end
    end

    task automatic note(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [DW-1:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [DW-1:0] exp, input string req);
        bus_addr = a;
        #1;
        note(req, bus_rdata, exp);
    endtask

    task automatic count_high(input int n, output int h);
        h = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out) h++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; bus_wr = 1'b0; sync_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Watchdog: a hung run is counted as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int h;
        @(negedge clk);
        do_reset();

        // R1: reset state
        cur_req = "R1";
        note("R1 out", pwm_out, 0);
        rd(A_PER, 0, "R1 per"); rd(A_CMP, 0, "R1 cmp");
        rd(A_PSH, 0, "R1 per_sh"); rd(A_CSH, 0, "R1 cmp_sh"); rd(A_CTL, 0, "R1 ctl");
        @(negedge clk);
        count_high(8, h); note("R1 idle low", h, 0);

        // R2: readback of every register
        cur_req = "R2";
        wr(A_PER, 32'h1234_5678); wr(A_CMP, 32'h0000_0055);
        wr(A_PSH, 32'h0000_0007); wr(A_CSH, 32'h0000_0003);
        wr(A_CTL, 32'hABCD_F1C3);
        rd(A_PER, 32'h1234_5678, "R2 per"); rd(A_CMP, 32'h55, "R2 cmp");
        rd(A_PSH, 7, "R2 per_sh"); rd(A_CSH, 3, "R2 cmp_sh");
        rd(A_CTL, 32'h0000_F1C3, "R2 ctl 16-bit");
        @(negedge clk);
        do_reset();

        // R3/R4/R7: normal polarity, period 4 (5 clocks), compare 2
        cur_req = "R4";
        wr(A_PER, 4); wr(A_CMP, 2);
        rd(A_PER, 4, "R7 direct per");
        @(negedge clk);
        wr(A_CTL, 32'h2D0);
        repeat (6) @(negedge clk);
        count_high(50, h); note("R3/R4 high clocks per 10 cycles", h, 20);

        // R3: stopped counter freezes the output level
        cur_req = "R3";
        wr(A_CTL, 32'h2C0);
        repeat (3) @(negedge clk);
        count_high(12, h); note("R3 frozen level", (h == 0 || h == 12), 1);

        // R5: inverted polarity
        cur_req = "R5";
        wr(A_CTL, 32'h6D0);
        repeat (6) @(negedge clk);
        count_high(50, h); note("R5 inverted high clocks", h, 30);

        // R6: mode bit clear holds low regardless of polarity
        cur_req = "R6";
        wr(A_CTL, 32'h4D0);
        repeat (3) @(negedge clk);
        count_high(20, h); note("R6 low with pol set", h, 0);

        // R4/R7: compare edge values written directly while running
        cur_req = "R4";
        wr(A_CTL, 32'h2D0);
        wr(A_CMP, 0);
        repeat (3) @(negedge clk);
        count_high(50, h); note("R4 compare 0 constant low", h, 0);
        wr(A_CMP, 9);
        repeat (3) @(negedge clk);
        count_high(50, h); note("R4/R7 compare above period constant high", h, 50);

        // R11: period 1, compare 1
        cur_req = "R11";
        wr(A_PER, 1); wr(A_CMP, 1);
        repeat (4) @(negedge clk);
        count_high(20, h); note("R11 alternating half duty", h, 10);

        // R8: staged writes wait for rollover
        cur_req = "R8";
        wr(A_PER, 4); wr(A_CMP, 2);
        repeat (6) @(negedge clk);
        wr(A_PSH, 9);
        rd(A_PER, 4, "R8 active period unchanged after staged write");
        wr(A_CSH, 5);
        rd(A_CMP, 2, "R8 active compare unchanged after staged write");
        repeat (12) @(negedge clk);
        rd(A_PER, 9, "R8 period moved at rollover");
        rd(A_CMP, 5, "R8 compare moved at rollover");
        @(negedge clk);
        count_high(50, h); note("R8 new duty", h, 25);

        // R9: staged write lands on the rollover clock
        cur_req = "R9";
        do_reset();
        wr(A_PER, 3); wr(A_CMP, 1); wr(A_PSH, 6);
        wr(A_CTL, 32'h2D0);
        repeat (3) @(negedge clk);
        wr(A_PSH, 11);
        rd(A_PER, 6, "R9 older pending value became active");
        rd(A_PSH, 11, "R9 new staged value held");
        repeat (10) @(negedge clk);
        rd(A_PER, 11, "R9 new value active after next rollover");
        @(negedge clk);

        // R10: sync clear versus sync deselected
        cur_req = "R10";
        wr(A_PER, 4); wr(A_CMP, 2);
        wr(A_CTL, 32'h210);
        sync_in = 1'b1;
        repeat (3) @(negedge clk);
        count_high(20, h); note("R10 sync holds count at 0", h, 20);
        wr(A_CTL, 32'h2D0);
        repeat (6) @(negedge clk);
        count_high(50, h); note("R10 sync ignored when deselected", h, 20);
        sync_in = 1'b0;
        repeat (3) @(negedge clk);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule